// File: doc/BRIEF.md
# Boundary Register Chain

This block is a chain of boundary register cells. Each cell sits between one device pin and the core logic. Every cell has two storage stages. The first is a capture/shift stage, clocked on the rising test-clock edge. It either loads its pin value or takes the bit from its upstream neighbour. The second is an update stage, clocked on the falling edge. It holds the value that is presented to the core while test mode is active.

The test access logic drives the control inputs. `scan_clk_en` marks the rising edges on which the capture/shift stage acts. `scan_sel` chooses between shifting and capturing. `upd_en` marks the falling edge on which the update stages load. `test_mode` switches every core-side output from its pin to its update stage. The test-mode multiplexer is separate from the shift path, so shifting a new word never disturbs the value being driven.

Top module: `bsr_chain`

## Requirements
- R1: An asynchronous low `rst_n` clears every capture/shift stage and every update stage to 0, so `ser_out` reads 0 and, with `test_mode` at 1, `core_out` reads all zeros.
- R2: With `test_mode` at 0, `core_out` equals `pin_in` bit for bit, with no clock involved.
- R3: On a rising `tck` edge with `scan_clk_en`=1 and `scan_sel`=1, cell i takes the value of cell i+1, and cell CELLS-1 takes `ser_in`. Cell 0 is the one nearest the serial output.
- R4: On a rising `tck` edge with `scan_clk_en`=1 and `scan_sel`=0, every cell i captures `pin_in[i]`.
- R5: On a rising `tck` edge with `scan_clk_en`=0, the capture/shift stages keep their values whatever `scan_sel`, `ser_in` and `pin_in` do.
- R6: On a falling `tck` edge with `upd_en`=1, every update stage copies its cell's capture/shift stage. With `upd_en`=0 the update stages hold.
- R7: With `test_mode` at 1, `core_out[i]` is the update stage of cell i, and changes of `pin_in` have no effect on it.
- R8: Shifting and capturing leave `core_out` unchanged while `test_mode` is 1 and no update occurs.
- R9: `ser_out` always shows cell 0. Shifting in a word over CELLS edges, least significant bit first, places bit i in cell i. Shifting out shows the old contents in order, cell 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture/shift on rising edge, update on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| scan_sel | input | 1 | 1 = shift serially, 0 = capture from pins |
| scan_clk_en | input | 1 | Enables the capture/shift stage on this rising edge |
| upd_en | input | 1 | Enables the update stage on this falling edge |
| test_mode | input | 1 | 1 = core side driven from update stages, 0 = pins pass through |
| ser_in | input | 1 | Serial input entering cell CELLS-1 |
| ser_out | output | 1 | Serial output taken from cell 0 |
| pin_in | input | CELLS | Pin-side parallel inputs, bit i to cell i |
| core_out | output | CELLS | Core-side parallel outputs, bit i from cell i |

## Verification
The hardest condition to reach is the one where the core-side output must stay frozen while the capture/shift stages are rewritten. That requires test mode to be on, the update latch to hold a known non-zero word, and a different word to be shifted through underneath it. The stimulus first captures and shifts a word and commits it with an update. It then shifts a second word while sampling `core_out` before every shift edge, and captures fresh pin values as well. Only a later, separate update may expose the second word. Each serial bit leaving the chain is also compared against a scoreboard filled with the previously loaded word.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } cap_op_e;

    typedef struct packed {
        logic data;
    } cap_state_t;

    typedef struct packed {
        logic data;
    } upd_state_t;

    function automatic cap_op_e decode_op(input logic clk_en, input logic sel);
        if (!clk_en)
            return OP_HOLD;
        else if (sel)
            return OP_SHIFT;
        else
            return OP_LOAD;
    endfunction

endpackage

// File: rtl/bsr_capture_stage.sv
module bsr_capture_stage
    import bsr_pkg::*;
(
    input  logic    tck,
    input  logic    rst_n,
    input  cap_op_e op,
    input  logic    par_in,
    input  logic    ser_in,
    output logic    cap_out
);

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        unique case (op)
            OP_LOAD:  cap_d.data = par_in;
            OP_SHIFT: cap_d.data = ser_in;
            default:  cap_d      = cap_q;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    assign cap_out = cap_q.data;

endmodule

// File: rtl/bsr_update_stage.sv
module bsr_update_stage
    import bsr_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic upd_en,
    input  logic cap_in,
    output logic upd_out
);

    upd_state_t upd_d, upd_q;

    always_comb begin
        upd_d = upd_q;
        if (upd_en)
            upd_d.data = cap_in;
    end

    // Falling edge: the update lands half a cycle after the last shift edge.
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)
            upd_q <= '0;
        else
            upd_q <= upd_d;
    end

    assign upd_out = upd_q.data;

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
(
    input  logic    tck,
    input  logic    rst_n,
    input  cap_op_e op,
    input  logic    upd_en,
    input  logic    test_mode,
    input  logic    par_in,
    input  logic    ser_in,
    output logic    ser_out,
    output logic    upd_val,
    output logic    par_out
);

    logic cap_val;

    bsr_capture_stage i_cap (
        .tck     (tck),
        .rst_n   (rst_n),
        .op      (op),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .cap_out (cap_val)
    );

    bsr_update_stage i_upd (
        .tck     (tck),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .cap_in  (cap_val),
        .upd_out (upd_val)
    );

    // Output multiplexer is steered only by test_mode, never by the shift path.
    always_comb begin
        par_out = test_mode ? upd_val : par_in;
    end

    assign ser_out = cap_val;

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int unsigned CELLS = 8
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             scan_sel,
    input  logic             scan_clk_en,
    input  logic             upd_en,
    input  logic             test_mode,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic [CELLS-1:0] pin_in,
    output logic [CELLS-1:0] core_out
);

    localparam int unsigned LINKS = CELLS + 1;

    cap_op_e          op;
    logic [CELLS-1:0] cap_vec;
    logic [CELLS-1:0] upd_vec;
    logic [LINKS-1:0] link;

    assign op   = decode_op(scan_clk_en, scan_sel);
    assign link = {ser_in, cap_vec};

    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        bsr_cell i_cell (
            .tck       (tck),
            .rst_n     (rst_n),
            .op        (op),
            .upd_en    (upd_en),
            .test_mode (test_mode),
            .par_in    (pin_in[g]),
            .ser_in    (link[g+1]),
            .ser_out   (cap_vec[g]),
            .upd_val   (upd_vec[g]),
            .par_out   (core_out[g])
        );
    end

    assign ser_out = link[0];

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
    parameter int unsigned CELLS = 8
) (
    input logic             tck,
    input logic             rst_n,
    input logic             scan_sel,
    input logic             scan_clk_en,
    input logic             upd_en,
    input logic             ser_in,
    input logic [CELLS-1:0] pin_in,
    input logic [CELLS-1:0] cap_vec,
    input logic [CELLS-1:0] upd_vec
);

    always @(posedge tck) begin
        if (rst_n === 1'b0) begin
            a_r1_reset_clear: assert (cap_vec == '0 && upd_vec == '0)
                else $error("R1: stages not cleared under reset");
        end
    end

    a_r3_entry_bit: assert property (@(posedge tck) disable iff (!rst_n)
        (scan_clk_en && scan_sel) |=> cap_vec[CELLS-1] == $past(ser_in));

    if (CELLS > 1) begin : g_multi
        a_r3_shift_toward_out: assert property (@(posedge tck) disable iff (!rst_n)
            (scan_clk_en && scan_sel) |=> cap_vec[CELLS-2:0] == $past(cap_vec[CELLS-1:1]));
    end

    a_r4_capture_pins: assert property (@(posedge tck) disable iff (!rst_n)
        (scan_clk_en && !scan_sel) |=> cap_vec == $past(pin_in));

    a_r5_hold_without_enable: assert property (@(posedge tck) disable iff (!rst_n)
        !scan_clk_en |=> $stable(cap_vec));

    a_r6_update_copies: assert property (@(negedge tck) disable iff (!rst_n)
        upd_en |=> upd_vec == $past(cap_vec));

    a_r6_update_holds: assert property (@(negedge tck) disable iff (!rst_n)
        !upd_en |=> $stable(upd_vec));

endmodule

bind bsr_chain bsr_chain_chk #(.CELLS(CELLS)) i_bsr_chain_chk (
    .tck         (tck),
    .rst_n       (rst_n),
    .scan_sel    (scan_sel),
    .scan_clk_en (scan_clk_en),
    .upd_en      (upd_en),
    .ser_in      (ser_in),
    .pin_in      (pin_in),
    .cap_vec     (cap_vec),
    .upd_vec     (upd_vec)
);

// File: tb/test_bsr_chain.sv
module test_bsr_chain;

    localparam int N        = 8;
    localparam int CLK_HALF = 5;
    localparam int WD_LIMIT = 200000;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_sel = 1'b0;
    logic         scan_clk_en = 1'b0;
    logic         upd_en = 1'b0;
    logic         test_mode = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] core_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #CLK_HALF tck = ~tck;

    bsr_chain #(.CELLS(N)) i_bsr_chain (
        .tck         (tck),
        .rst_n       (rst_n),
        .scan_sel    (scan_sel),
        .scan_clk_en (scan_clk_en),
        .upd_en      (upd_en),
        .test_mode   (test_mode),
        .ser_in      (ser_in),
        .ser_out     (ser_out),
        .pin_in      (pin_in),
        .core_out    (core_out)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard for the serial output stream
    typedef struct {
        logic  bit_v;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     smp_ev;

    always begin
        sb_item_t it;
        @(smp_ev);
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            chk(it.tag, N'(ser_out), N'(it.bit_v));
        end
    end

    // Driver: shifts new_w in LSB first; expects old_w to leave cell 0 first.
    task automatic shift_word(input logic [N-1:0] new_w, input logic [N-1:0] old_w,
                              input string tag, input bit hold_chk, input logic [N-1:0] hold_v);
        for (int k = 0; k < N; k++) begin
            @(negedge tck);
            #1;
            scan_sel    = 1'b1;
            scan_clk_en = 1'b1;
            ser_in      = new_w[k];
            sb_q.push_back('{bit_v: old_w[k], tag: tag});
            ->smp_ev;
            #2;
            if (hold_chk) chk("R8 core_out frozen during shift", core_out, hold_v);
            @(posedge tck);
        end
        @(negedge tck);
        #1;
        scan_clk_en = 1'b0;
        scan_sel    = 1'b0;
    endtask

    task automatic capture();
        @(negedge tck);
        #1;
        scan_sel    = 1'b0;
        scan_clk_en = 1'b1;
        @(posedge tck);
        @(negedge tck);
        #1;
        scan_clk_en = 1'b0;
    endtask

    task automatic do_update();
        @(posedge tck);
        #1;
        upd_en = 1'b1;
        @(negedge tck);
        #1;
        upd_en = 1'b0;
    endtask

    initial begin
        logic [N-1:0] pats [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};

        // R1: reset state
        test_mode = 1'b1;
        pin_in    = 8'hFF;
        repeat (3) @(posedge tck);
        #1;
        chk("R1 core_out after reset", core_out, '0);
        chk("R1 ser_out after reset", N'(ser_out), '0);
        @(negedge tck);
        #1;
        rst_n = 1'b1;

        // R2: transparent path
        test_mode = 1'b0;
        foreach (pats[i]) begin
            pin_in = pats[i];
            #1;
            chk("R2 transparent", core_out, pats[i]);
        end

        // R4 capture, then R9 shift-out order of captured word
        pin_in = 8'hB6;
        capture();
        pin_in = 8'h00;
        shift_word(8'h5A, 8'hB6, "R4 captured bit on ser_out", 1'b0, '0);

        // R5: no enable, inputs toggling
        @(negedge tck);
        #1;
        scan_sel = 1'b1;
        ser_in   = 1'b1;
        pin_in   = 8'hFF;
        repeat (4) @(posedge tck);
        @(negedge tck);
        #1;
        chk("R5 hold ser_out", N'(ser_out), '0);
        scan_sel = 1'b0;

        // R7 before any update, R6 update exposes held word (proves R5 too)
        test_mode = 1'b1;
        pin_in    = 8'h0F;
        #1;
        chk("R7 core_out from reset latch", core_out, '0);
        do_update();
        #1;
        chk("R6 update copies word", core_out, 8'h5A);

        // R8 / R3: shift new word under a frozen output
        shift_word(8'hC3, 8'h5A, "R3 shift order", 1'b1, 8'h5A);
        repeat (3) @(negedge tck);
        #1;
        chk("R6 no update without upd_en", core_out, 8'h5A);
        do_update();
        #1;
        chk("R9 full word after N shifts", core_out, 8'hC3);

        pin_in = 8'hE7;
        capture();
        #1;
        chk("R8 core_out frozen after capture", core_out, 8'hC3);
        pin_in = 8'h18;
        #1;
        chk("R7 pin change ignored", core_out, 8'hC3);

        test_mode = 1'b0;
        #1;
        chk("R2 transparent again", core_out, 8'h18);
        test_mode = 1'b1;
        #1;
        chk("R7 latch retained", core_out, 8'hC3);

        shift_word(8'h00, 8'hE7, "R9 captured word out", 1'b1, 8'hC3);

        // R1: asynchronous reset mid-run
        @(negedge tck);
        #1;
        rst_n = 1'b0;
        #1;
        chk("R1 async clear core_out", core_out, '0);
        chk("R1 async clear ser_out", N'(ser_out), '0);
        @(negedge tck);
        #1;
        rst_n = 1'b1;
        shift_word(8'hFF, 8'h00, "R1 cleared chain", 1'b0, '0);

        @(negedge tck);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge tck);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule